// File: doc/BRIEF.md
# Decoded micro-op cache

This block keeps copies of the micro-op bundles that the instruction decoder produces, so that a later fetch of the same address can be served without decoding again. Each fetch window maps to exactly one slot through its index bits. A stored tag decides whether the slot holds that window. Every bundle that leaves the decoder is written, with no filtering. A new fill simply displaces whatever occupied its slot.

The fetch stage presents an address each cycle it wants a lookup. One cycle later the block reports a hit flag and the stored bundle. A registered sleep signal tells the decoder it may be idled while hits continue, and it wakes the decoder in the same cycle a miss is reported. The enclosing instruction cache reports each line it evicts. Every entry that holds a window of that line is dropped at once, so this block never holds anything the instruction cache does not hold.

With the default parameters there are 256 slots of six micro-ops each, which gives 1536 micro-ops in total.

Top module: `uop_cache`

## Requirements
- R1: After reset no slot is valid, hit_o and dec_sleep_o are 0 and uops_o is all zeros, and any lookup misses until a fill is made.
- R2: A lookup presented in cycle t reports hit_o=1 in cycle t+1 when the selected slot is valid and its tag matches; uops_o then carries the bundle stored with that window.
- R3: When a lookup misses, or when no lookup is presented, hit_o is 0 and uops_o is all zeros in the following cycle.
- R4: Every fill whose line is not being invalidated in the same cycle is written, whatever the slot held before. A fill to an address that shares the slot with a different tag displaces the older window, and that older window then misses.
- R5: A lookup reflects the contents as they stood before any fill or invalidate applied in the same cycle. A fill made in cycle t is visible to lookups from cycle t+1.
- R6: An invalidate of line L in cycle t clears, at that edge, every valid entry whose window lies in L, including all windows of L held in different slots. Entries of other lines are kept.
- R7: A fill and an invalidate in the same cycle that name the same line drop the fill, so the window is not present afterwards.
- R8: dec_sleep_o is set in the cycle a hit is reported and cleared in the cycle a miss is reported. It holds its value across cycles with no lookup.
- R9: Address fields: window = address >> FETCH_OFF_W; slot = low IDX_W bits of the window; tag = the remaining upper window bits; line = address >> LINE_OFF_W. Addresses that differ only below FETCH_OFF_W select the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en_i | input | 1 | Decoder delivers a bundle this cycle |
| fill_addr_i | input | ADDR_W | Fetch address of the decoded bundle |
| fill_uops_i | input | UOPS*UOP_W | Decoded micro-op bundle |
| lk_en_i | input | 1 | Fetch requests a lookup this cycle |
| lk_addr_i | input | ADDR_W | Fetch address to look up |
| inv_en_i | input | 1 | Instruction cache evicts a line this cycle |
| inv_line_i | input | ADDR_W-LINE_OFF_W | Line address of the evicted line |
| hit_o | output | 1 | Previous cycle's lookup hit |
| uops_o | output | UOPS*UOP_W | Bundle for the hit, zero otherwise |
| dec_sleep_o | output | 1 | Decoder may be powered down |

## Verification
The bench builds the cache with a 12-bit address, 8 slots, 4-byte fetch windows, 8-byte lines and two 8-bit micro-ops per entry. With so few slots, random addresses in a 256-byte range collide in the same slot all the time, so displacement and same-cycle fill/lookup races happen often. With two windows per line, one invalidate has to clear two slots at once, and a fill and an invalidate can be aimed at the same line from neighbouring windows. Directed cases pin down each of these orderings before the random phase.

// File: rtl/uopc_pkg.sv
`timescale 1ns/1ps
package uopc_pkg;

  // fetch window number of a byte address
  function automatic logic [63:0] window_of(input logic [63:0] addr, input int unsigned off_w);
    return addr >> off_w;
  endfunction

  // slot selected by an address (direct mapped)
  function automatic logic [63:0] slot_of(input logic [63:0] addr, input int unsigned off_w,
                                          input int unsigned idx_w);
    return window_of(addr, off_w) & ((64'd1 << idx_w) - 64'd1);
  endfunction

  // tag held for an address
  function automatic logic [63:0] tag_of(input logic [63:0] addr, input int unsigned off_w,
                                         input int unsigned idx_w);
    return window_of(addr, off_w) >> idx_w;
  endfunction

  // instruction-cache line that a stored (tag, slot) pair belongs to
  function automatic logic [63:0] line_of_entry(input logic [63:0] tag, input logic [63:0] slot,
                                                input int unsigned idx_w, input int unsigned lsh);
    return ((tag << idx_w) | slot) >> lsh;
  endfunction

endpackage

// File: rtl/uopc_store.sv
`timescale 1ns/1ps
module uopc_store #(
  parameter int IDX_W    = 8,
  parameter int TAG_W    = 20,
  parameter int BUNDLE_W = 192,
  parameter int LINE_A_W = 26,
  parameter int LSH      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_en,
  input  logic [IDX_W-1:0]    fill_idx,
  input  logic [TAG_W-1:0]    fill_tag,
  input  logic [BUNDLE_W-1:0] fill_data,
  input  logic                inv_en,
  input  logic [LINE_A_W-1:0] inv_line,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [BUNDLE_W-1:0] rd_data,
  output logic                fill_blocked
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0]  valid_q;
  logic [ENTRIES-1:0]  fill_sel;
  logic [ENTRIES-1:0]  inv_hit;
  logic [TAG_W-1:0]    tag_q  [ENTRIES];
  logic [BUNDLE_W-1:0] data_q [ENTRIES];
  logic [LINE_A_W-1:0] fill_line;
  logic                fill_ok;

  assign fill_line    = LINE_A_W'(uopc_pkg::line_of_entry(64'(fill_tag), 64'(fill_idx), IDX_W, LSH));
  assign fill_blocked = fill_en && inv_en && (fill_line == inv_line);
  assign fill_ok      = fill_en && !fill_blocked;

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [LINE_A_W-1:0] ent_line;
      assign ent_line    = LINE_A_W'(uopc_pkg::line_of_entry(64'(tag_q[e]), 64'(e), IDX_W, LSH));
      assign fill_sel[e] = fill_ok && (fill_idx == IDX_W'(e));
      assign inv_hit[e]  = inv_en && valid_q[e] && (ent_line == inv_line);

      // R6
      r6_inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_hit[e] && !fill_sel[e] |=> !valid_q[e]);
      // R4
      r4_fill_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_sel[e] |=> valid_q[e] && (tag_q[e] == $past(fill_tag)));
      // R7
      r7_fill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_blocked && (fill_idx == IDX_W'(e)) |=> !(valid_q[e] && (tag_q[e] == $past(fill_tag))));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (fill_sel[e])     valid_q[e] <= 1'b1;
        else if (inv_hit[e]) valid_q[e] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      tag_q[fill_idx]  <= fill_tag;
      data_q[fill_idx] <= fill_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/uopc_lookup.sv
`timescale 1ns/1ps
module uopc_lookup #(
  parameter int TAG_W    = 20,
  parameter int BUNDLE_W = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_en,
  input  logic [TAG_W-1:0]    lk_tag,
  input  logic                rd_valid,
  input  logic [TAG_W-1:0]    rd_tag,
  input  logic [BUNDLE_W-1:0] rd_data,
  output logic                lk_hit,
  output logic                lk_miss,
  output logic                hit_q,
  output logic [BUNDLE_W-1:0] uops_q
);
  assign lk_hit  = lk_en && rd_valid && (rd_tag == lk_tag);
  assign lk_miss = lk_en && !lk_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      uops_q <= '0;
    end else begin
      hit_q  <= lk_hit;
      uops_q <= lk_hit ? rd_data : '0;
    end
  end

  // R2
  r2_hit_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> hit_q);
  // R3
  r3_miss_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> !hit_q && (uops_q == '0));
endmodule

// File: rtl/uopc_gate.sv
`timescale 1ns/1ps
module uopc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lk_hit,
  input  logic lk_miss,
  output logic sleep_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sleep_q <= 1'b0;
    else if (lk_hit)  sleep_q <= 1'b1;
    else if (lk_miss) sleep_q <= 1'b0;
  end

  // R8
  r8_sleep_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> sleep_q);
  // R8
  r8_wake_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> !sleep_q);
  // R8
  r8_sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit && !lk_miss |=> $stable(sleep_q));
endmodule

// File: rtl/uop_cache.sv
`timescale 1ns/1ps
module uop_cache #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 8,
  parameter int FETCH_OFF_W = 4,
  parameter int LINE_OFF_W  = 6,
  parameter int UOPS        = 6,
  parameter int UOP_W       = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_en_i,
  input  logic [ADDR_W-1:0]           fill_addr_i,
  input  logic [UOPS*UOP_W-1:0]       fill_uops_i,
  input  logic                        lk_en_i,
  input  logic [ADDR_W-1:0]           lk_addr_i,
  input  logic                        inv_en_i,
  input  logic [ADDR_W-LINE_OFF_W-1:0] inv_line_i,
  output logic                        hit_o,
  output logic [UOPS*UOP_W-1:0]       uops_o,
  output logic                        dec_sleep_o
);
  localparam int BUNDLE_W = UOPS * UOP_W;
  localparam int TAG_W    = ADDR_W - FETCH_OFF_W - IDX_W;
  localparam int LINE_A_W = ADDR_W - LINE_OFF_W;
  localparam int LSH      = LINE_OFF_W - FETCH_OFF_W;

  logic [IDX_W-1:0]    fill_idx, lk_idx;
  logic [TAG_W-1:0]    fill_tag, lk_tag, rd_tag;
  logic [BUNDLE_W-1:0] rd_data;
  logic                rd_valid, lk_hit, lk_miss, fill_blocked;

  assign fill_idx = IDX_W'(uopc_pkg::slot_of(64'(fill_addr_i), FETCH_OFF_W, IDX_W));
  assign fill_tag = TAG_W'(uopc_pkg::tag_of(64'(fill_addr_i), FETCH_OFF_W, IDX_W));
  assign lk_idx   = IDX_W'(uopc_pkg::slot_of(64'(lk_addr_i), FETCH_OFF_W, IDX_W));
  assign lk_tag   = TAG_W'(uopc_pkg::tag_of(64'(lk_addr_i), FETCH_OFF_W, IDX_W));

  uopc_store #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .BUNDLE_W(BUNDLE_W), .LINE_A_W(LINE_A_W), .LSH(LSH)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en_i), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_uops_i),
    .inv_en(inv_en_i), .inv_line(inv_line_i),
    .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .fill_blocked(fill_blocked)
  );

  uopc_lookup #(.TAG_W(TAG_W), .BUNDLE_W(BUNDLE_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .lk_en(lk_en_i), .lk_tag(lk_tag),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .hit_q(hit_o), .uops_q(uops_o)
  );

  uopc_gate u_gate (
    .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_miss(lk_miss), .sleep_q(dec_sleep_o)
  );

  // R3
  r3_idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en_i |=> !hit_o && (uops_o == '0));
  // R8
  r8_sleep_tracks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> dec_sleep_o);
  // R7
  r7_drop_same_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en_i && inv_en_i && (LINE_A_W'(fill_addr_i >> LINE_OFF_W) == inv_line_i) |-> fill_blocked);
endmodule

// File: tb/uop_cache_tb.sv
`timescale 1ns/1ps
module uop_cache_tb;
  localparam int AW = 12, IW = 3, FO = 2, LO = 3, NU = 2, UW = 8;
  localparam int BW = NU * UW;
  localparam int LAW = AW - LO;
  localparam int NE = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fill_en_i = 1'b0, lk_en_i = 1'b0, inv_en_i = 1'b0;
  logic [AW-1:0] fill_addr_i = '0, lk_addr_i = '0;
  logic [BW-1:0] fill_uops_i = '0;
  logic [LAW-1:0] inv_line_i = '0;
  logic hit_o, dec_sleep_o;
  logic [BW-1:0] uops_o;

  always #2.5 clk = ~clk;

  uop_cache #(.ADDR_W(AW), .IDX_W(IW), .FETCH_OFF_W(FO), .LINE_OFF_W(LO), .UOPS(NU), .UOP_W(UW))
  u_dut (.*);

  int checks = 0, errors = 0;

  bit            m_valid [NE];
  int unsigned   m_win   [NE];
  logic [BW-1:0] m_data  [NE];
  bit            m_sleep = 1'b0;

  function automatic int unsigned b_win(int unsigned a);  return a / (1 << FO); endfunction
  function automatic int unsigned b_slot(int unsigned a); return b_win(a) % NE; endfunction
  function automatic int unsigned b_line(int unsigned a); return a / (1 << LO); endfunction

  task automatic check(string tag, bit eh, logic [BW-1:0] eu, bit es);
    checks++;
    if (hit_o !== eh || uops_o !== eu || dec_sleep_o !== es) begin
      errors++;
      $display("FAIL %s: hit=%0d uops=%h sleep=%0d expected hit=%0d uops=%h sleep=%0d",
               tag, hit_o, uops_o, dec_sleep_o, eh, eu, es);
    end
  endtask

  task automatic cyc(string tag, bit fe, int unsigned fa, logic [BW-1:0] fd,
                     bit le, int unsigned la, bit ie, int unsigned il);
    int unsigned s, fs;
    bit eh, blocked;
    logic [BW-1:0] eu;
    fill_en_i = fe; fill_addr_i = AW'(fa); fill_uops_i = fd;
    lk_en_i = le;   lk_addr_i = AW'(la);
    inv_en_i = ie;  inv_line_i = LAW'(il);
    s  = b_slot(la);
    eh = le && m_valid[s] && (m_win[s] == b_win(la));
    eu = eh ? m_data[s] : '0;
    if (le) m_sleep = eh;
    fs = b_slot(fa);
    blocked = fe && ie && (b_line(fa) == il);
    for (int e = 0; e < NE; e++) begin
      if (fe && !blocked && e == int'(fs)) begin
        m_valid[e] = 1'b1; m_win[e] = b_win(fa); m_data[e] = fd;
      end else if (ie && m_valid[e] && (m_win[e] / (1 << (LO - FO)) == il)) begin
        m_valid[e] = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, eh, eu, m_sleep);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int e = 0; e < NE; e++) begin m_valid[e] = 1'b0; m_win[e] = 0; m_data[e] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    cyc("R1 empty lookup",       0, 0, '0, 1, 12'h040, 0, 0);
    cyc("R4 fill A",             1, 12'h040, 16'h1234, 0, 0, 0, 0);
    cyc("R2 hit A",              0, 0, '0, 1, 12'h040, 0, 0);
    cyc("R9 offset bits ignored",0, 0, '0, 1, 12'h043, 0, 0);
    cyc("R3 idle holds sleep",   0, 0, '0, 0, 0, 0, 0);
    cyc("R9 next window misses", 0, 0, '0, 1, 12'h044, 0, 0);
    cyc("R2 rehit A",            0, 0, '0, 1, 12'h040, 0, 0);
    cyc("R8 alias miss wakes",   0, 0, '0, 1, 12'h060, 0, 0);
    cyc("R4 fill alias B",       1, 12'h060, 16'hBEEF, 0, 0, 0, 0);
    cyc("R4 A displaced",        0, 0, '0, 1, 12'h040, 0, 0);
    cyc("R5 fill C with lookup B", 1, 12'h080, 16'hC0DE, 1, 12'h060, 0, 0);
    cyc("R5 C visible next",     0, 0, '0, 1, 12'h080, 0, 0);
    cyc("R6 fill w0",            1, 12'h100, 16'h0A0A, 0, 0, 0, 0);
    cyc("R6 fill w1",            1, 12'h104, 16'h0B0B, 0, 0, 0, 0);
    cyc("R6 fill other line",    1, 12'h108, 16'h0C0C, 0, 0, 0, 0);
    cyc("R5 lookup during inval",0, 0, '0, 1, 12'h104, 1, 12'h100 / 8);
    cyc("R6 w0 gone",            0, 0, '0, 1, 12'h100, 0, 0);
    cyc("R6 w1 gone",            0, 0, '0, 1, 12'h104, 0, 0);
    cyc("R6 other line kept",    0, 0, '0, 1, 12'h108, 0, 0);
    cyc("R7 fill and inval same line", 1, 12'h114, 16'h7777, 0, 0, 1, 12'h110 / 8);
    cyc("R7 fill dropped",       0, 0, '0, 1, 12'h114, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      bit fe, le, ie;
      int unsigned fa, la, il;
      fe = ($urandom % 2) == 0;
      le = ($urandom % 10) < 7;
      ie = ($urandom % 10) == 0;
      fa = $urandom % 256;
      la = $urandom % 256;
      il = ($urandom % 256) / 8;
      cyc("R2 random", fe, fa, BW'($urandom), le, la, ie, il);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule